// File: doc/BRIEF.md
# Eight-Bit Interval Timer with Square-Wave and Pulse-Width Output

This block is an 8-bit up-counter clocked by a selectable prescaled tick. It drives one output level and one interrupt pulse. A control register selects one of two output behaviours and a tick rate, and it holds a run bit. In square-wave (divider) mode the counter runs up to the data register value, then clears, and the output toggles. The output is therefore a square wave whose half period equals the data value in ticks. In pulse-width mode the counter runs freely over 256 ticks. The output is high at the start of each period and falls when the count reaches the duty value. It rises again, and the interrupt fires, when the counter wraps.

In pulse-width mode the duty value is double-buffered. Software writes a staging register at any time. The staged value moves into the active compare register only when a period ends, or when the run bit goes from 0 to 1. A write in the same cycle as the transfer is taken directly, so it always wins. When the timer is not running, the counter is held at zero and the output rests high.

Top module: `pwm_div_timer`

## Requirements
- R1: After reset, `tmr_out` is 1 and `tmr_irq` is 0.
- R2: The control word has mode in bits [1:0], tick select in bits [4:2] and the run bit in bit 5. Mode 2'b10 is divider, 2'b11 is pulse-width, and 2'b00/2'b01 keep the timer inactive: output high, no interrupt, even with the run bit set.
- R3: Tick select 0 gives one tick per clock. Select s≥1 gives one tick every 2^(7+3·(s−1)) clocks. The prescaler restarts from zero when the run bit rises, so the first counter step comes exactly one tick period after the start write.
- R4: In divider mode with data value N (N=0 meaning 256), the output is 1 from the start write, then toggles every N ticks, first toggling to 0 N ticks after the start edge.
- R5: In divider mode, `tmr_irq` is high for exactly the one cycle that follows each toggle.
- R6: In pulse-width mode with active duty N, the output is 1 for the first N ticks of each 256-tick period, counted from the start edge or from a wrap, and 0 for the rest. N=0 gives an output that stays 0.
- R7: In pulse-width mode, `tmr_irq` is high for one cycle following each counter wrap, every 256 ticks.
- R8: A data write during a pulse-width period does not change that period. It takes effect from the next wrap.
- R9: The value in the data register when the run bit rises becomes the active duty of the first period.
- R10: A data write in the same cycle as a wrap transfer becomes the active duty of the next period, replacing any earlier staged value.
- R11: Clearing the run bit forces the output high one cycle after the control write takes effect, even in the middle of a low phase. The counter is held at zero and no interrupt occurs until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control word: run[5], tick select[4:2], mode[1:0] |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Half-period (divider) or duty (pulse-width) value |
| tmr_out | output | 1 | Timer output level |
| tmr_irq | output | 1 | One-cycle interrupt pulse |

## Verification
Divider mode is tried with a small half period, which shows the toggle spacing and the cycle in which the interrupt pulses. It is also tried with zero, which must become a 256-tick half period instead of a stuck counter. A slow prescaled tick is run twice, with a misaligned pause between the runs, to show that the prescaler restarts on start. Pulse-width mode is tried with a mid-range duty and with zero duty. Separate runs write the duty in the middle of a period, to show the buffering, and on the exact wrap cycle, after an earlier staged value, to show that the late write wins. Stopping during a low phase and starting with a reserved mode show the idle-high rule.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE0 = 2'b00,
    MODE_IDLE1 = 2'b01,
    MODE_DIV   = 2'b10,
    MODE_PWM   = 2'b11
  } tmr_mode_e;

  // Prescaler exponent for a tick select code: 0 = every clock.
  function automatic int unsigned sel_exp(input int unsigned sel,
                                          input int unsigned base,
                                          input int unsigned step);
    if (sel == 0) return 0;
    return base + step * (sel - 1);
  endfunction

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned BASE_EXP = 7,
  parameter int unsigned STEP_EXP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import timer_pkg::*;

  localparam int unsigned PRE_W = BASE_EXP + STEP_EXP * ((1 << SEL_W) - 2);

  logic [PRE_W-1:0] pre_q, pre_d, mask;
  int unsigned      exp_w;

  always_comb begin
    exp_w = sel_exp(int'(sel), BASE_EXP, STEP_EXP);
    for (int unsigned i = 0; i < PRE_W; i++) begin
      mask[i] = (i < exp_w);
    end
  end

  always_comb begin
    if (!run || restart) pre_d = '0;
    else                 pre_d = pre_q + PRE_W'(1);
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));

endmodule

// File: rtl/duty_buffer.sv
module duty_buffer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic [CNT_W-1:0] data_wdata,
  input  logic             load_en,
  output logic [CNT_W-1:0] stage_q,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] active_q
);
  logic [CNT_W-1:0] stage_d, active_d;

  // A write in the transfer cycle bypasses the staging register.
  assign load_val = data_we ? data_wdata : stage_q;

  always_comb begin
    stage_d  = data_we ? data_wdata : stage_q;
    active_d = load_en ? load_val : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      stage_q  <= stage_d;
      active_q <= active_d;
    end
  end

  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(active_q));

  // R10
  late_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && data_we) |=> (active_q == $past(data_wdata)));

endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  timer_pkg::tmr_mode_e mode,
  input  logic                tick,
  input  logic                start_load,
  input  timer_pkg::tmr_mode_e start_mode,
  input  logic [CNT_W-1:0]    div_val,
  input  logic [CNT_W-1:0]    active_val,
  input  logic [CNT_W-1:0]    load_val,
  output logic                load_en,
  output logic                out_q,
  output logic                irq_q
);
  import timer_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             out_d, irq_d, wrap_load;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d     = cnt_q;
    out_d     = out_q;
    irq_d     = 1'b0;
    wrap_load = 1'b0;
    if (start_load) begin
      cnt_d = '0;
      out_d = (start_mode == MODE_PWM) ? (load_val != '0) : 1'b1;
    end else if (!run) begin
      cnt_d = '0;
      out_d = 1'b1;
    end else if (tick) begin
      if (mode == MODE_DIV) begin
        if (cnt_inc == div_val) begin
          cnt_d = '0;
          out_d = ~out_q;
          irq_d = 1'b1;
        end else begin
          cnt_d = cnt_inc;
        end
      end else begin
        cnt_d = cnt_inc;
        if (cnt_q == '1) begin
          out_d     = (load_val != '0);
          irq_d     = 1'b1;
          wrap_load = 1'b1;
        end else if (cnt_inc == active_val) begin
          out_d = 1'b0;
        end
      end
    end
  end

  assign load_en = start_load | wrap_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
      irq_q <= irq_d;
    end
  end

  // R11
  stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_load) |=> (out_q && cnt_q == '0));

  // R5
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(run && tick));

  // R4
  div_toggle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MODE_DIV && !$stable(out_q)) |-> irq_q);

  // R7
  pwm_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MODE_PWM && $rose(out_q)) |-> irq_q);

endmodule

// File: rtl/pwm_div_timer.sv
module pwm_div_timer #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned BASE_EXP = 7,
  parameter int unsigned STEP_EXP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic [SEL_W+2:0]   ctrl_wdata,
  input  logic               data_we,
  input  logic [CNT_W-1:0]   data_wdata,
  output logic               tmr_out,
  output logic               tmr_irq
);
  import timer_pkg::*;

  localparam int unsigned CTRL_W  = SEL_W + 3;
  localparam int unsigned RUN_BIT = SEL_W + 2;

  logic              rst_meta_q, rst_sync_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              start_rise, run;
  tmr_mode_e         mode, start_mode;
  logic              tick, load_en;
  logic [CNT_W-1:0]  stage_q, load_val, active_q;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    ctrl_d = ctrl_we ? ctrl_wdata : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) ctrl_q <= '0;
    else             ctrl_q <= ctrl_d;
  end

  assign mode       = tmr_mode_e'(ctrl_q[1:0]);
  assign start_mode = tmr_mode_e'(ctrl_wdata[1:0]);
  assign start_rise = ctrl_we && ctrl_wdata[RUN_BIT] && !ctrl_q[RUN_BIT];
  assign run        = ctrl_q[RUN_BIT] && (mode == MODE_DIV || mode == MODE_PWM);

  timer_prescaler #(
    .SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP)
  ) u_prescaler (
    .clk(clk), .rst_n(rst_sync_q), .run(run), .restart(start_rise),
    .sel(ctrl_q[RUN_BIT-1:2]), .tick(tick)
  );

  duty_buffer #(.CNT_W(CNT_W)) u_duty (
    .clk(clk), .rst_n(rst_sync_q), .data_we(data_we), .data_wdata(data_wdata),
    .load_en(load_en), .stage_q(stage_q), .load_val(load_val), .active_q(active_q)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sync_q), .run(run), .mode(mode), .tick(tick),
    .start_load(start_rise), .start_mode(start_mode), .div_val(stage_q),
    .active_val(active_q), .load_val(load_val), .load_en(load_en),
    .out_q(tmr_out), .irq_q(tmr_irq)
  );

  // R2
  idle_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ctrl_q[RUN_BIT] && (mode == MODE_IDLE0 || mode == MODE_IDLE1) && !ctrl_we)
      |=> (tmr_out && !tmr_irq));

endmodule

// File: tb/pwm_div_timer_bench.sv
module pwm_div_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_we;
  logic [5:0] ctrl_wdata;
  logic       data_we;
  logic [7:0] data_wdata;
  logic       tmr_out, tmr_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwm_div_timer u_pwm_div_timer (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .data_we(data_we), .data_wdata(data_wdata),
    .tmr_out(tmr_out), .tmr_irq(tmr_irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic stop_timer();
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 6'b000000;
    @(negedge clk);
    ctrl_we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Stage d0, start the timer, and compare every cycle against the model.
  // pwm: mode 2'b11, else 2'b10. T: clocks per tick. Writes wv1/wv2 land at edges wk1/wk2.
  task automatic watch(input bit pwm, input logic [2:0] sel, input logic [7:0] d0,
                       input logic [7:0] d1, input int t, input int ncyc,
                       input int wk1, input logic [7:0] wv1,
                       input int wk2, input logic [7:0] wv2, input string req);
    int bad_o = 0, bad_i = 0;
    int fo_k = -1, fo_a = 0, fo_e = 0, fi_k = -1, fi_a = 0, fi_e = 0;
    @(negedge clk);
    data_we = 1'b1; data_wdata = d0;
    @(negedge clk);
    data_we = 1'b0;
    ctrl_we = 1'b1; ctrl_wdata = {1'b1, sel, pwm ? 2'b11 : 2'b10};
    @(negedge clk);
    ctrl_we = 1'b0;
    for (int k = 0; k < ncyc; k++) begin
      bit eo, ei;
      if (pwm) begin
        int j = k / t;
        int d = ((j / 256) == 0) ? int'(d0) : int'(d1);
        eo = ((j % 256) < d);
        ei = (k > 0) && (k % (256 * t) == 0);
      end else begin
        int n = (d0 == 0) ? 256 : int'(d0);
        eo = (((k / (t * n)) % 2) == 0);
        ei = (k > 0) && (k % (t * n) == 0);
      end
      if (tmr_out !== eo) begin
        bad_o++;
        if (fo_k < 0) begin fo_k = k; fo_a = int'(tmr_out); fo_e = int'(eo); end
      end
      if (tmr_irq !== ei) begin
        bad_i++;
        if (fi_k < 0) begin fi_k = k; fi_a = int'(tmr_irq); fi_e = int'(ei); end
      end
      if (k + 1 == wk1) begin data_we = 1'b1; data_wdata = wv1; end
      else if (k + 1 == wk2) begin data_we = 1'b1; data_wdata = wv2; end
      else data_we = 1'b0;
      @(negedge clk);
    end
    data_we = 1'b0;
    check(bad_o == 0, req, $sformatf("output level (first bad edge %0d)", fo_k), fo_a, fo_e);
    check(bad_i == 0, req, $sformatf("interrupt (first bad edge %0d)", fi_k), fi_a, fi_e);
  endtask

  task automatic test_reset();
    check(tmr_out === 1'b1, "R1", "output after reset", int'(tmr_out), 1);
    check(tmr_irq === 1'b0, "R1", "irq after reset", int'(tmr_irq), 0);
  endtask

  task automatic test_divider();
    watch(1'b0, 3'd0, 8'd5, 8'd5, 1, 60, -1, 8'd0, -1, 8'd0, "R4 R5 N=5");
    stop_timer();
    watch(1'b0, 3'd0, 8'd0, 8'd0, 1, 600, -1, 8'd0, -1, 8'd0, "R4 N=0");
    stop_timer();
  endtask

  task automatic test_prescaler();
    watch(1'b0, 3'd1, 8'd2, 8'd2, 128, 1100, -1, 8'd0, -1, 8'd0, "R3 sel1 first");
    stop_timer();
    repeat (37) @(negedge clk);
    watch(1'b0, 3'd1, 8'd2, 8'd2, 128, 1100, -1, 8'd0, -1, 8'd0, "R3 sel1 restart");
    stop_timer();
  endtask

  task automatic test_pwm_basic();
    watch(1'b1, 3'd0, 8'h40, 8'h40, 1, 600, -1, 8'd0, -1, 8'd0, "R6 R7 R9 duty 64");
    stop_timer();
    watch(1'b1, 3'd0, 8'd0, 8'd0, 1, 600, -1, 8'd0, -1, 8'd0, "R6 duty 0");
    stop_timer();
  endtask

  task automatic test_pwm_buffered();
    watch(1'b1, 3'd0, 8'd100, 8'd200, 1, 600, 50, 8'd200, -1, 8'd0, "R8 mid-period write");
    stop_timer();
    watch(1'b1, 3'd0, 8'd100, 8'd30, 1, 600, 100, 8'd200, 256, 8'd30, "R10 write on wrap");
    stop_timer();
  endtask

  task automatic test_start_load();
    @(negedge clk);
    data_we = 1'b1; data_wdata = 8'd77;
    @(negedge clk);
    data_we = 1'b0;
    repeat (5) @(negedge clk);
    check(tmr_out === 1'b1, "R9", "output before start", int'(tmr_out), 1);
    watch(1'b1, 3'd0, 8'd77, 8'd77, 1, 300, -1, 8'd0, -1, 8'd0, "R9 start load");
    stop_timer();
  endtask

  task automatic test_stop_low();
    int bad = 0;
    watch(1'b1, 3'd0, 8'd10, 8'd10, 1, 21, -1, 8'd0, -1, 8'd0, "R11 pre-stop");
    // now just after edge E21; output is low (count past 10)
    ctrl_we = 1'b1; ctrl_wdata = 6'b000011;
    @(negedge clk);
    ctrl_we = 1'b0;
    check(tmr_out === 1'b0, "R11", "output still low at stop edge", int'(tmr_out), 0);
    @(negedge clk);
    check(tmr_out === 1'b1, "R11", "output high after stop", int'(tmr_out), 1);
    for (int k = 0; k < 300; k++) begin
      if (tmr_out !== 1'b1 || tmr_irq !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R11", "cycles not idle while stopped", bad, 0);
  endtask

  task automatic test_idle_mode();
    int bad = 0;
    @(negedge clk);
    data_we = 1'b1; data_wdata = 8'd5;
    ctrl_we = 1'b1; ctrl_wdata = 6'b100001;
    @(negedge clk);
    data_we = 1'b0; ctrl_we = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (tmr_out !== 1'b1 || tmr_irq !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R2", "active cycles in mode 01", bad, 0);
    stop_timer();
  endtask

  initial begin
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; data_we = 1'b0; data_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_divider();
    test_prescaler();
    test_pwm_basic();
    test_pwm_buffered();
    test_start_load();
    test_stop_low();
    test_idle_mode();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule